// File: doc/BRIEF.md
# Asynchronous fault status logger

This unit collects error reports from the checkers of a processor's memory subsystem and presents them to software as two memory-mapped registers. Each report is a one-cycle pulse that carries an error type, a 9-bit data ECC syndrome, a 4-bit tag ECC syndrome, a physical address, a privilege flag and a flag marking it as part of a 64-byte bus transfer. The status register holds one sticky bit per error type, a repeat flag, a privilege flag and two captured syndrome fields. A second register holds one captured fault address.

The syndrome fields and the address each keep the report of highest priority. A field stays locked on that report until software clears the sticky bit that belongs to it. Clearing any other bit leaves the lock in place. A trap request output stays high while an enabled, trap-capable sticky bit is set and the global interrupt enable is high. Software clears bits by writing ones. Reads have one cycle of latency and never change state.

Top module: `fsl_fault_logger`

## Requirements
- R1: A report with type code t (0..18) sets status bit 33+t. The bit stays set until it is cleared by a write. Type codes 19 and above are dropped with no effect. Classes, with priority from high to low: system-bus uncorrectable = {1, 12, 14}; cache uncorrectable = {2, 4, 6, 8}; software-correctable = {9}; hardware-corrected = {0, 3, 5, 7, 13, 15}; no capture = {10, 11, 16, 17, 18}.
- R2: A write to address 0 clears each of bits 53, 52 and 51:33 whose write-data bit is 1. Bits written as 0 keep their value. The syndrome fields cannot be changed by a write, and a read clears nothing.
- R3: Bit 53 (repeat flag) is set when a report of an uncorrectable or software-correctable class arrives while its own sticky bit is already set. A repeated hardware-corrected report does not set it.
- R4: After `xfer_start`, only the first accepted report with `evt_burst` high is logged. Any later report with `evt_burst` high is ignored completely, including for bit 53, until the next `xfer_start`. A `xfer_start` in the same cycle as a report lets that report through.
- R5: Bit 52 is set by any accepted report that has `evt_priv` high.
- R6: Status bits 8:0 hold the data syndrome and bits 19:16 hold the tag syndrome. Types 14 and 15 feed the tag syndrome. All other capture-class types feed the data syndrome. A field is overwritten only by a report of strictly higher priority, so the first arrival wins among equals.
- R7: Address 8 reads the captured fault address, zero-extended to 64 bits. Any capture-class report may load it under the same priority and first-arrival rule. Writes to address 8 have no effect.
- R8: Clearing the one sticky bit that a locked field belongs to unlocks that field, even while other sticky bits remain set. The field keeps its value until the next capture, and a capture can occur in the same cycle as the clear.
- R9: When a write clears a bit in the same cycle that a report sets it, the bit stays set, and any field locked on that bit stays locked.
- R10: `trap_req` is registered. It equals `intr_en` AND the OR of the sticky bits selected by TRAP_MASK (default 0x0B2AB over type codes), both taken from the previous cycle.
- R11: A read request gives `rd_valid` high on the next cycle, with the register contents from the request cycle. Addresses other than 0 and 8 read as zero.
- R12: After reset, every register field, `trap_req` and `rd_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error report pulse |
| evt_type | input | 5 | Error type code |
| evt_dsyn | input | 9 | Data ECC syndrome |
| evt_tsyn | input | 4 | Tag ECC syndrome |
| evt_addr | input | ADDR_W | Physical address of the fault |
| evt_priv | input | 1 | Privileged mode at detection |
| evt_burst | input | 1 | Report belongs to the current 64-byte transfer |
| xfer_start | input | 1 | Start of a new 64-byte transfer |
| intr_en | input | 1 | Global interrupt enable |
| reg_valid | input | 1 | Register access request |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 64 | Write data (ones clear) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| trap_req | output | 1 | Disrupting trap request |

## Verification
The bench goes after the lock rules. It covers an equal-priority repeat that must not move the captured address, a lower-priority report that arrives while a lock is held, and a clear of an unrelated bit, which must leave the lock alone. A design that unlocked on any clear, or that overwrote on equal priority, would show a changed syndrome or address. It also checks a clear that collides with a new report of the same type, where a wrong design drops the bit. It checks repeated reports inside one burst, where a wrong design sets bit 53 or a second sticky bit. Finally it checks the hardware-corrected repeat, which must not raise the repeat flag.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  localparam int NUM_ERR    = 19;
  localparam int TYPE_W     = 5;
  localparam int STICKY_LSB = 33;
  localparam int PRIV_BIT   = 52;
  localparam int ME_BIT     = 53;
  localparam int DSYN_W     = 9;
  localparam int TSYN_W     = 4;
  localparam int TSYN_LSB   = 16;
  localparam int PRIO_W     = 3;

  typedef enum logic [PRIO_W-1:0] {
    CLS_NONE = 3'd0,
    CLS_HWC  = 3'd1,
    CLS_SWC  = 3'd2,
    CLS_UEC  = 3'd3,
    CLS_UEB  = 3'd4
  } err_cls_e;

  function automatic err_cls_e class_of(input logic [TYPE_W-1:0] t);
    case (t)
      5'd1, 5'd12, 5'd14:                     return CLS_UEB;
      5'd2, 5'd4, 5'd6, 5'd8:                 return CLS_UEC;
      5'd9:                                   return CLS_SWC;
      5'd0, 5'd3, 5'd5, 5'd7, 5'd13, 5'd15:   return CLS_HWC;
      default:                                return CLS_NONE;
    endcase
  endfunction

  function automatic logic feeds_tag(input logic [TYPE_W-1:0] t);
    return (t == 5'd14) || (t == 5'd15);
  endfunction
endpackage

// File: rtl/fsl_event_gate.sv
module fsl_event_gate
  import fsl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_valid,
  input  logic [TYPE_W-1:0]    evt_type,
  input  logic                 evt_burst,
  input  logic                 xfer_start,
  output logic                 accept,
  output logic [NUM_ERR-1:0]   set_vec,
  output err_cls_e             cls,
  output logic                 tag_kind
);
  logic burst_seen_q;
  logic type_ok;

  assign type_ok  = (evt_type < TYPE_W'(NUM_ERR));
  assign accept   = evt_valid && type_ok && (xfer_start || !evt_burst || !burst_seen_q);
  assign cls      = accept ? class_of(evt_type) : CLS_NONE;
  assign tag_kind = feeds_tag(evt_type);

  always_comb begin
    set_vec = '0;
    if (accept) set_vec[evt_type] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             burst_seen_q <= 1'b0;
    else if (xfer_start) burst_seen_q <= evt_valid && evt_burst && type_ok;
    else if (accept && evt_burst) burst_seen_q <= 1'b1;
  end
endmodule

// File: rtl/fsl_lock_capture.sv
module fsl_lock_capture
  import fsl_pkg::*;
#(
  parameter int W = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_en,
  input  logic [PRIO_W-1:0]    cap_prio,
  input  logic [TYPE_W-1:0]    cap_idx,
  input  logic [W-1:0]         cap_val,
  input  logic [NUM_ERR-1:0]   clr_eff,
  output logic [W-1:0]         val_q
);
  logic              held_q;
  logic [PRIO_W-1:0] prio_q;
  logic [TYPE_W-1:0] idx_q;
  logic              release_now;
  logic              take;

  assign release_now = held_q && clr_eff[idx_q];
  assign take        = cap_en && (!held_q || release_now || (cap_prio > prio_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      prio_q <= '0;
      idx_q  <= '0;
      val_q  <= '0;
    end else if (take) begin
      held_q <= 1'b1;
      prio_q <= cap_prio;
      idx_q  <= cap_idx;
      val_q  <= cap_val;
    end else if (release_now) begin
      held_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fsl_fault_logger.sv
module fsl_fault_logger
  import fsl_pkg::*;
#(
  parameter int                ADDR_W    = 40,
  parameter int                REG_AW    = 4,
  parameter logic [18:0]       TRAP_MASK = 19'h0B2AB
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_valid,
  input  logic [4:0]           evt_type,
  input  logic [8:0]           evt_dsyn,
  input  logic [3:0]           evt_tsyn,
  input  logic [ADDR_W-1:0]    evt_addr,
  input  logic                 evt_priv,
  input  logic                 evt_burst,
  input  logic                 xfer_start,
  input  logic                 intr_en,
  input  logic                 reg_valid,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [63:0]          reg_wdata,
  output logic                 rd_valid,
  output logic [63:0]          rd_data,
  output logic                 trap_req
);
  localparam int STICKY_MSB = STICKY_LSB + NUM_ERR - 1;
  localparam logic [REG_AW-1:0] STAT_ADR = REG_AW'(0);
  localparam logic [REG_AW-1:0] ADR_ADR  = REG_AW'(8);

  logic               accept, tag_kind;
  logic [NUM_ERR-1:0] set_vec, wr_clr, clr_eff, sticky_q;
  err_cls_e           cls;
  logic               me_q, priv_q, wr_stat, me_set;
  logic [DSYN_W-1:0]  dsyn_q;
  logic [TSYN_W-1:0]  tsyn_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [63:0]        stat_word, addr_word;
  logic               unused_wd;

  fsl_event_gate u_gate (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_type(evt_type),
    .evt_burst(evt_burst), .xfer_start(xfer_start), .accept(accept),
    .set_vec(set_vec), .cls(cls), .tag_kind(tag_kind)
  );

  assign wr_stat = reg_valid && reg_we && (reg_addr == STAT_ADR);
  assign wr_clr  = wr_stat ? reg_wdata[STICKY_MSB:STICKY_LSB] : '0;
  assign clr_eff = wr_clr & ~set_vec;
  assign me_set  = accept && (cls >= CLS_SWC) && ((sticky_q & set_vec) != '0);
  assign unused_wd = ^{reg_wdata[63:ME_BIT+1], reg_wdata[STICKY_LSB-1:0]};

  fsl_lock_capture #(.W(DSYN_W)) u_dsyn (
    .clk(clk), .rst(rst),
    .cap_en(accept && (cls != CLS_NONE) && !tag_kind),
    .cap_prio(cls), .cap_idx(evt_type), .cap_val(evt_dsyn),
    .clr_eff(clr_eff), .val_q(dsyn_q)
  );

  fsl_lock_capture #(.W(TSYN_W)) u_tsyn (
    .clk(clk), .rst(rst),
    .cap_en(accept && (cls != CLS_NONE) && tag_kind),
    .cap_prio(cls), .cap_idx(evt_type), .cap_val(evt_tsyn),
    .clr_eff(clr_eff), .val_q(tsyn_q)
  );

  fsl_lock_capture #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst),
    .cap_en(accept && (cls != CLS_NONE)),
    .cap_prio(cls), .cap_idx(evt_type), .cap_val(evt_addr),
    .clr_eff(clr_eff), .val_q(addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      me_q     <= 1'b0;
      priv_q   <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~wr_clr) | set_vec;
      me_q     <= (me_q && !(wr_stat && reg_wdata[ME_BIT])) || me_set;
      priv_q   <= (priv_q && !(wr_stat && reg_wdata[PRIV_BIT])) || (accept && evt_priv);
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[ME_BIT]                   = me_q;
    stat_word[PRIV_BIT]                 = priv_q;
    stat_word[STICKY_MSB:STICKY_LSB]    = sticky_q;
    stat_word[TSYN_LSB+TSYN_W-1:TSYN_LSB] = tsyn_q;
    stat_word[DSYN_W-1:0]               = dsyn_q;
    addr_word = 64'(addr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      trap_req <= 1'b0;
    end else begin
      trap_req <= intr_en && ((sticky_q & TRAP_MASK) != '0);
      rd_valid <= reg_valid && !reg_we;
      if (reg_valid && !reg_we) begin
        if (reg_addr == STAT_ADR)     rd_data <= stat_word;
        else if (reg_addr == ADR_ADR) rd_data <= addr_word;
        else                          rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/fsl_checker.sv
module fsl_checker #(
  parameter int ADDR_W = 40,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic              reg_valid,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              intr_en,
  input logic              trap_req,
  input logic              rd_valid,
  input logic [18:0]       sticky,
  input logic              me,
  input logic [ADDR_W-1:0] addr_val
);
  // R1: sticky bits only fall after a status write
  a_r1_sticky_no_fall: assert property (@(posedge clk) disable iff (rst)
    !(reg_valid && reg_we && reg_addr == '0) |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R3: repeat flag rises only because of a report
  a_r3_me_needs_event: assert property (@(posedge clk) disable iff (rst)
    $rose(me) |-> $past(evt_valid));

  // R7: captured address moves only on a report
  a_r7_addr_quiet: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> $stable(addr_val));

  // R10: no trap request without the enable
  a_r10_trap_gated: assert property (@(posedge clk) disable iff (rst)
    !intr_en |=> !trap_req);

  // R11: read data valid follows a read request
  a_r11_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(reg_valid && !reg_we));
endmodule

bind fsl_fault_logger fsl_checker #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .reg_valid(reg_valid),
  .reg_we(reg_we), .reg_addr(reg_addr), .intr_en(intr_en), .trap_req(trap_req),
  .rd_valid(rd_valid), .sticky(sticky_q), .me(me_q), .addr_val(addr_q)
);

// File: tb/fsl_fault_logger_tb_top.sv
`timescale 1ns/1ps
module fsl_fault_logger_tb_top;
  localparam int AW = 40;
  localparam logic [18:0] MASK = 19'h0B2AB;

  logic clk = 0, rst = 1;
  logic evt_valid = 0, evt_priv = 0, evt_burst = 0, xfer_start = 0, intr_en = 0;
  logic [4:0] evt_type = 0;
  logic [8:0] evt_dsyn = 0;
  logic [3:0] evt_tsyn = 0;
  logic [AW-1:0] evt_addr = 0;
  logic reg_valid = 0, reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic rd_valid, trap_req;
  logic [63:0] rd_data;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  fsl_fault_logger dut_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_type(evt_type),
    .evt_dsyn(evt_dsyn), .evt_tsyn(evt_tsyn), .evt_addr(evt_addr),
    .evt_priv(evt_priv), .evt_burst(evt_burst), .xfer_start(xfer_start),
    .intr_en(intr_en), .reg_valid(reg_valid), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .trap_req(trap_req)
  );

  // reference model state
  logic [18:0] m_sticky;
  logic m_me, m_priv, m_seen, m_trap, m_rdv;
  logic [63:0] m_rd;
  logic m_held[3];
  int m_prio[3], m_idx[3];
  logic [63:0] m_val[3];

  function automatic int bcls(int t);
    if (t == 1 || t == 12 || t == 14) return 4;
    if (t == 2 || t == 4 || t == 6 || t == 8) return 3;
    if (t == 9) return 2;
    if (t == 0 || t == 3 || t == 5 || t == 7 || t == 13 || t == 15) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] mword();
    return {10'b0, m_me, m_priv, m_sticky, 13'b0, m_val[1][3:0], 7'b0, m_val[0][8:0]};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sticky = 0; m_me = 0; m_priv = 0; m_seen = 0; m_trap = 0; m_rdv = 0; m_rd = 0;
    for (int u = 0; u < 3; u++) begin m_held[u] = 0; m_prio[u] = 0; m_idx[u] = 0; m_val[u] = 0; end
  endtask

  task automatic tick();
    logic acc, wst, n_trap, n_rdv, tagk, en, live;
    logic [63:0] n_rd, v;
    logic [18:0] setv, wclr, clre;
    int c, t;
    t = int'(evt_type);
    n_trap = intr_en && ((m_sticky & MASK) != 0);
    n_rdv = reg_valid && !reg_we;
    n_rd = m_rd;
    if (n_rdv) n_rd = (reg_addr == 0) ? mword() : (reg_addr == 8) ? {24'b0, m_val[2][AW-1:0]} : 64'b0;
    acc = evt_valid && t < 19 && (xfer_start || !evt_burst || !m_seen);
    if (xfer_start) m_seen = evt_valid && evt_burst && t < 19;
    else if (acc && evt_burst) m_seen = 1;
    setv = acc ? (19'd1 << t) : 19'd0;
    wst = reg_valid && reg_we && reg_addr == 0;
    wclr = wst ? reg_wdata[51:33] : 19'd0;
    clre = wclr & ~setv;
    c = acc ? bcls(t) : 0;
    tagk = (t == 14 || t == 15);
    m_me = (m_me && !(wst && reg_wdata[53])) || (acc && c >= 2 && (m_sticky & setv) != 0);
    m_priv = (m_priv && !(wst && reg_wdata[52])) || (acc && evt_priv);
    m_sticky = (m_sticky & ~wclr) | setv;
    for (int u = 0; u < 3; u++) begin
      en = acc && c != 0 && ((u == 0) ? !tagk : (u == 1) ? tagk : 1'b1);
      v = (u == 0) ? 64'(evt_dsyn) : (u == 1) ? 64'(evt_tsyn) : 64'(evt_addr);
      live = m_held[u] && !clre[m_idx[u]];
      if (en && (!live || c > m_prio[u])) begin
        m_held[u] = 1; m_prio[u] = c; m_idx[u] = t; m_val[u] = v;
      end else if (m_held[u] && clre[m_idx[u]]) m_held[u] = 0;
    end
    @(negedge clk);
    m_trap = n_trap; m_rdv = n_rdv; m_rd = n_rd;
    chk(trap_req === m_trap, "R10 trap_req", 64'(trap_req), 64'(m_trap));
    chk(rd_valid === m_rdv, "R11 rd_valid", 64'(rd_valid), 64'(m_rdv));
    if (m_rdv) chk(rd_data === m_rd, "R11 rd_data", rd_data, m_rd);
    evt_valid = 0; evt_burst = 0; xfer_start = 0; evt_priv = 0;
    reg_valid = 0; reg_we = 0;
  endtask

  task automatic ev(int t, logic [8:0] ds, logic [3:0] ts, logic [AW-1:0] a,
                    logic pv, logic bu, logic xs);
    evt_valid = 1; evt_type = 5'(t); evt_dsyn = ds; evt_tsyn = ts; evt_addr = a;
    evt_priv = pv; evt_burst = bu; xfer_start = xs;
    tick();
  endtask

  task automatic wr(logic [63:0] d);
    reg_valid = 1; reg_we = 1; reg_addr = 0; reg_wdata = d;
    tick();
  endtask

  task automatic rd(logic [3:0] a);
    reg_valid = 1; reg_we = 0; reg_addr = a;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk(trap_req === 0 && rd_valid === 0, "R12 outputs", {62'b0, trap_req, rd_valid}, 0);
    rd(0); chk(rd_data === 0, "R12 status", rd_data, 0);
    rd(8); chk(rd_data === 0, "R12 address", rd_data, 0);
    // hardware-corrected repeat
    ev(0, 9'h011, 0, 40'h10_0000_0040, 0, 0, 0);
    ev(0, 9'h022, 0, 40'h10_0000_0080, 0, 0, 0);
    rd(0);
    chk(rd_data[33] === 1, "R1 sticky set", 64'(rd_data[33]), 1);
    chk(rd_data[53] === 0, "R3 hwc repeat no flag", 64'(rd_data[53]), 0);
    chk(rd_data[8:0] === 9'h011, "R6 first arrival", 64'(rd_data[8:0]), 64'h011);
    rd(0); chk(rd_data[33] === 1, "R2 read does not clear", 64'(rd_data[33]), 1);
    rd(8); chk(rd_data === 64'h10_0000_0040, "R7 first addr", rd_data, 64'h10_0000_0040);
    // higher priority overwrites, priv
    ev(1, 9'h133, 0, 40'h20_0000_0100, 1, 0, 0);
    rd(0);
    chk(rd_data[8:0] === 9'h133, "R6 overwrite", 64'(rd_data[8:0]), 64'h133);
    chk(rd_data[52] === 1, "R5 priv", 64'(rd_data[52]), 1);
    ev(1, 9'h144, 0, 40'h20_0000_0200, 0, 0, 0);
    rd(0); chk(rd_data[53] === 1, "R3 ue repeat flag", 64'(rd_data[53]), 1);
    rd(8); chk(rd_data === 64'h20_0000_0100, "R7 equal prio kept", rd_data, 64'h20_0000_0100);
    // clear unrelated bit
    wr(64'd1 << 33);
    rd(0);
    chk(rd_data[34:33] === 2'b10, "R2 selective clear", 64'(rd_data[34:33]), 2);
    ev(3, 9'h055, 0, 40'h30_0000_0000, 0, 0, 0);
    rd(0); chk(rd_data[8:0] === 9'h133, "R8 lock held", 64'(rd_data[8:0]), 64'h133);
    // clear owner
    wr(64'd1 << 34);
    rd(0); chk(rd_data[8:0] === 9'h133, "R8 content kept", 64'(rd_data[8:0]), 64'h133);
    ev(3, 9'h066, 0, 40'h30_0000_0040, 0, 0, 0);
    rd(0); chk(rd_data[8:0] === 9'h066, "R8 unlocked capture", 64'(rd_data[8:0]), 64'h066);
    // set wins over clear
    reg_valid = 1; reg_we = 1; reg_addr = 0; reg_wdata = 64'd1 << 36;
    ev(3, 9'h077, 0, 40'h30_0000_0080, 0, 0, 0);
    rd(0);
    chk(rd_data[36] === 1, "R9 set wins", 64'(rd_data[36]), 1);
    chk(rd_data[8:0] === 9'h066, "R9 lock stays", 64'(rd_data[8:0]), 64'h066);
    // tag syndrome
    ev(14, 9'h1FF, 4'hA, 40'h40_0000_0000, 0, 0, 0);
    rd(0);
    chk(rd_data[19:16] === 4'hA, "R6 tag field", 64'(rd_data[19:16]), 64'hA);
    chk(rd_data[8:0] === 9'h066, "R6 data untouched", 64'(rd_data[8:0]), 64'h066);
    rd(8); chk(rd_data === 64'h40_0000_0000, "R7 addr overwrite", rd_data, 64'h40_0000_0000);
    reg_valid = 1; reg_we = 1; reg_addr = 8; reg_wdata = '1; tick();
    rd(8); chk(rd_data === 64'h40_0000_0000, "R7 write ignored", rd_data, 64'h40_0000_0000);
    // clear all; syndromes read-only
    wr('1);
    rd(0);
    chk(rd_data === 64'h000A_0066, "R2 clear all", rd_data, 64'h000A_0066);
    // burst filter
    xfer_start = 1; tick();
    ev(8, 9'h0AA, 0, 40'h50_0000_0000, 0, 1, 0);
    ev(8, 9'h0BB, 0, 40'h50_0000_0010, 0, 1, 0);
    ev(9, 9'h0CC, 0, 40'h50_0000_0020, 0, 1, 0);
    rd(0);
    chk(rd_data[53] === 0, "R4 no repeat flag", 64'(rd_data[53]), 0);
    chk(rd_data[42:41] === 2'b01, "R4 later ignored", 64'(rd_data[42:41]), 1);
    chk(rd_data[8:0] === 9'h0AA, "R4 first logged", 64'(rd_data[8:0]), 64'h0AA);
    ev(9, 9'h0DD, 0, 40'h50_0000_0030, 0, 1, 1);
    rd(0); chk(rd_data[42] === 1, "R4 new transfer", 64'(rd_data[42]), 1);
    ev(30, 9'h001, 0, 0, 0, 0, 0);
    rd(0); chk(rd_data[51:33] === 19'h300, "R1 bad type dropped", 64'(rd_data[51:33]), 64'h300);
    // trap
    intr_en = 1; tick(); tick();
    chk(trap_req === 1, "R10 trap on", 64'(trap_req), 1);
    intr_en = 0; tick();
    chk(trap_req === 0, "R10 trap off", 64'(trap_req), 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      evt_valid = ($urandom % 3) == 0;
      evt_type = 5'($urandom % 21);
      evt_dsyn = 9'($urandom); evt_tsyn = 4'($urandom);
      evt_addr = {8'($urandom), 32'($urandom)};
      evt_priv = ($urandom % 4) == 0;
      evt_burst = ($urandom % 4) == 0;
      xfer_start = ($urandom % 8) == 0;
      intr_en = $urandom % 2;
      r = $urandom % 8;
      reg_valid = r < 5;
      reg_we = r == 0;
      reg_addr = (r == 3) ? 4'd8 : (r == 4) ? 4'd4 : 4'd0;
      reg_wdata = {32'($urandom), 32'($urandom)} & {32'($urandom), 32'($urandom)};
      tick();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule